// File: doc/BRIEF.md
# Cache Invalidate-All Sequencer

This block clears an entire cache when software asks it to. It owns a control register. Writing that register with the invalidate bit set launches a walk over every set of the cache. The walk visits one set per clock. For each set it drives a tag-array write that clears both the valid state and the modified state of every way in that set. While the walk runs, the block holds a stall towards the load/store path, so no data access can see a partly cleared cache.

When the last set has been written, the invalidate bit drops to 0 without any help from software. A one-cycle completion pulse marks that same cycle. Software can therefore poll the register: the bit reads 1 until the cache is clean. Reset returns the register to zero but never touches the arrays. Their contents survive reset until this command clears them. Writing back dirty lines before the walk is software's job.

Top module: `cache_inval_seq`

## Requirements
- R1: A register write whose bit INV_BIT (default 24) is 1, made while no walk runs, starts a walk. From the next cycle `tag_wr_en` is 1 with `tag_wr_set` = 0, and `ls_stall` is 1.
- R2: A register write whose bit INV_BIT is 0 starts no walk. The other bits are stored and read back unchanged on `cfg_rd_data`.
- R3: The walk writes sets 0, 1, …, NUM_SETS-1 in ascending order, one per cycle, with no gap. It makes exactly NUM_SETS tag writes.
- R4: Every tag write has `tag_wr_way_mask` all ones, `tag_wr_valid` all zeros and `tag_wr_dirty` all zeros. This clears the valid and modified state of every way.
- R5: `ls_stall` is 1 in exactly the cycles in which the walk issues tag writes, and 0 otherwise.
- R6: Bit INV_BIT of `cfg_rd_data` reads 1 for every cycle of the walk. It reads 0 from the cycle after the write to set NUM_SETS-1.
- R7: `inv_done` is 1 for exactly one cycle. That is the cycle in which bit INV_BIT of `cfg_rd_data` returns to 0.
- R8: A write with bit INV_BIT = 1 made during a walk, including its last cycle, neither restarts nor extends the walk. The other bits of that write are still stored.
- R9: Reset clears the register, `ls_stall` and `inv_done` to 0 and issues no tag write. A reset during a walk stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | CTRL_W | Control register write data |
| cfg_rd_data | output | CTRL_W | Control register read value |
| ls_stall | output | 1 | Stall to the load/store path during a walk |
| tag_wr_en | output | 1 | Tag array write enable |
| tag_wr_set | output | $clog2(NUM_SETS) | Set index being cleared |
| tag_wr_way_mask | output | NUM_WAYS | Ways written in this step |
| tag_wr_valid | output | NUM_WAYS | Valid bits written per way |
| tag_wr_dirty | output | NUM_WAYS | Modified bits written per way |
| inv_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same clock edge, and the risky case is their overlap. One is a fresh write of 1 to the invalidate bit. The other is the walk's final step, when the bit clears itself. The bench sweeps the position of a second write of 1 across every cycle of the walk, including the last. The expected result is always the same: exactly NUM_SETS ascending tag writes, followed by one done cycle. The bench also issues a new start in the cycle right after completion, which must begin a full new walk, and checks the stored non-command bits on every cycle.

// File: rtl/ci_pkg.sv
// Package: shared types for the invalidate-all sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package ci_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/ci_ctrl_reg.sv
// Module: ci_ctrl_reg
// Holds the control register. The command bit at INV_BIT is set by a write of 1
// while idle and is cleared by the walker's final-step strobe. All other bits
// are plain storage.
// Assumes: walk_last is asserted for exactly one cycle per walk.
module ci_ctrl_reg #(
    parameter int CTRL_W  = 32,
    parameter int INV_BIT = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              walk_last,
    output logic              start,
    output logic [CTRL_W-1:0] rd_data
);
    localparam logic [CTRL_W-1:0] INV_MASK = CTRL_W'(1) << INV_BIT;

    logic [CTRL_W-1:0] other_q;
    logic              inv_q;

    // Launch request: a 1 in the command bit, accepted only while no walk is pending.
    always_comb begin
        start = wr_en && wr_data[INV_BIT] && !inv_q;
    end

    // Store the non-command bits on any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            other_q <= '0;
        end else if (wr_en) begin
            other_q <= wr_data & ~INV_MASK;
        end
    end

    // Command bit: set on launch, cleared when the walker finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
        end else if (start) begin
            inv_q <= 1'b1;
        end else if (walk_last) begin
            inv_q <= 1'b0;
        end
    end

    // Assemble the read value.
    always_comb begin
        rd_data = other_q;
        rd_data[INV_BIT] = inv_q;
    end
endmodule

// File: rtl/ci_walker.sv
// Module: ci_walker
// Steps a set index from 0 to NUM_SETS-1, one set per cycle, after a start.
// Flags the final step and raises a registered done pulse one cycle later.
// Assumes: NUM_SETS >= 2. Starts are never presented while running.
module ci_walker
    import ci_pkg::*;
#(
    parameter int NUM_SETS = 8,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [SET_W-1:0] set_idx,
    output logic             last,
    output logic             done
);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    walk_state_e      state_q;
    logic [SET_W-1:0] cnt_q;

    // Decode the status outputs from the state and the index.
    always_comb begin
        busy    = (state_q == WALK_RUN);
        set_idx = cnt_q;
        last    = busy && (cnt_q == LAST_SET);
    end

    // Walk state and set index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    if (start) begin
                        state_q <= WALK_RUN;
                        cnt_q   <= '0;
                    end
                end
                WALK_RUN: begin
                    if (cnt_q == LAST_SET) begin
                        state_q <= WALK_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + SET_W'(1);
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // One-cycle completion pulse after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= last;
        end
    end
endmodule

// File: rtl/ci_tag_drv.sv
// Module: ci_tag_drv
// Forms the tag-array write that clears the valid and modified state of every way.
// Assumes: the tag array takes a per-way write mask and per-way valid and dirty data.
module ci_tag_drv #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                busy,
    input  logic [SET_W-1:0]    set_idx,
    output logic                wr_en,
    output logic [SET_W-1:0]    wr_set,
    output logic [NUM_WAYS-1:0] way_mask,
    output logic [NUM_WAYS-1:0] valid,
    output logic [NUM_WAYS-1:0] dirty
);
    // Enable and address follow the walker directly.
    always_comb begin
        wr_en  = busy;
        wr_set = set_idx;
    end

    // Per-way write lanes: select every way and write zeros.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign way_mask[w] = busy;
        assign valid[w]    = 1'b0;
        assign dirty[w]    = 1'b0;
    end
endmodule

// File: rtl/cache_inval_seq.sv
// Module: cache_inval_seq (top)
// Invalidate-all sequencer: control register, set walker and tag write driver.
// Stalls the load/store path for the whole walk.
// Assumes: software has already written back dirty lines before it issues the command.
module cache_inval_seq #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int CTRL_W   = 32,
    parameter int INV_BIT  = 24,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CTRL_W-1:0]   cfg_wr_data,
    output logic [CTRL_W-1:0]   cfg_rd_data,
    output logic                ls_stall,
    output logic                tag_wr_en,
    output logic [SET_W-1:0]    tag_wr_set,
    output logic [NUM_WAYS-1:0] tag_wr_way_mask,
    output logic [NUM_WAYS-1:0] tag_wr_valid,
    output logic [NUM_WAYS-1:0] tag_wr_dirty,
    output logic                inv_done
);
    logic             start;
    logic             busy;
    logic             last;
    logic [SET_W-1:0] set_idx;

    ci_ctrl_reg #(.CTRL_W(CTRL_W), .INV_BIT(INV_BIT)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .walk_last (last),
        .start     (start),
        .rd_data   (cfg_rd_data)
    );

    ci_walker #(.NUM_SETS(NUM_SETS)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .set_idx (set_idx),
        .last    (last),
        .done    (inv_done)
    );

    ci_tag_drv #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_tag (
        .busy     (busy),
        .set_idx  (set_idx),
        .wr_en    (tag_wr_en),
        .wr_set   (tag_wr_set),
        .way_mask (tag_wr_way_mask),
        .valid    (tag_wr_valid),
        .dirty    (tag_wr_dirty)
    );

    // Stall data accesses for every cycle of the walk.
    always_comb begin
        ls_stall = busy;
    end
endmodule

// File: rtl/ci_seq_chk.sv
// Module: ci_seq_chk
// Checker bound to cache_inval_seq. It relates the stall, the tag writes, the
// read-back command bit and the done pulse over time.
// Assumes: synchronous active-low reset.
module ci_seq_chk #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int CTRL_W   = 32,
    parameter int INV_BIT  = 24,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CTRL_W-1:0]   cfg_rd_data,
    input logic                ls_stall,
    input logic                tag_wr_en,
    input logic [SET_W-1:0]    tag_wr_set,
    input logic [NUM_WAYS-1:0] tag_wr_way_mask,
    input logic [NUM_WAYS-1:0] tag_wr_valid,
    input logic [NUM_WAYS-1:0] tag_wr_dirty,
    input logic                inv_done
);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    // R1
    walk_begins_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_wr_en) |-> (tag_wr_set == '0));

    // R3
    set_steps_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_wr_en && tag_wr_set != LAST_SET) |=>
            (tag_wr_en && tag_wr_set == $past(tag_wr_set) + SET_W'(1)));

    // R3
    walk_ends_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_wr_en && tag_wr_set == LAST_SET) |=> (!tag_wr_en && inv_done));

    // R4
    clear_all_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr_en |-> (tag_wr_way_mask == '1 && tag_wr_valid == '0 && tag_wr_dirty == '0));

    // R5
    stall_matches_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_stall == tag_wr_en);

    // R6
    busy_reads_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr_en |-> cfg_rd_data[INV_BIT]);

    // R7
    done_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> (!cfg_rd_data[INV_BIT] && $fell(ls_stall)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_done);
endmodule

bind cache_inval_seq ci_seq_chk #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .CTRL_W   (CTRL_W),
    .INV_BIT  (INV_BIT)
) u_ci_seq_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_rd_data     (cfg_rd_data),
    .ls_stall        (ls_stall),
    .tag_wr_en       (tag_wr_en),
    .tag_wr_set      (tag_wr_set),
    .tag_wr_way_mask (tag_wr_way_mask),
    .tag_wr_valid    (tag_wr_valid),
    .tag_wr_dirty    (tag_wr_dirty),
    .inv_done        (inv_done)
);

// File: tb/tb_cache_inval_seq.sv
module tb_cache_inval_seq;
    localparam int NUM_SETS = 8;
    localparam int NUM_WAYS = 4;
    localparam int CTRL_W   = 32;
    localparam int INV_BIT  = 24;
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam logic [CTRL_W-1:0] INV_MASK = CTRL_W'(1) << INV_BIT;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_wr_en = 1'b0;
    logic [CTRL_W-1:0]   cfg_wr_data = '0;
    logic [CTRL_W-1:0]   cfg_rd_data;
    logic                ls_stall;
    logic                tag_wr_en;
    logic [SET_W-1:0]    tag_wr_set;
    logic [NUM_WAYS-1:0] tag_wr_way_mask;
    logic [NUM_WAYS-1:0] tag_wr_valid;
    logic [NUM_WAYS-1:0] tag_wr_dirty;
    logic                inv_done;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [CTRL_W-1:0] exp_other = '0;

    always #2.5 clk = ~clk;

    cache_inval_seq #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS),
                      .CTRL_W(CTRL_W), .INV_BIT(INV_BIT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .ls_stall(ls_stall), .tag_wr_en(tag_wr_en),
        .tag_wr_set(tag_wr_set), .tag_wr_way_mask(tag_wr_way_mask),
        .tag_wr_valid(tag_wr_valid), .tag_wr_dirty(tag_wr_dirty), .inv_done(inv_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive inputs at the falling edge, then sample 1 ns after the rising edge.
    task automatic cyc(input logic en, input logic [CTRL_W-1:0] d);
        @(negedge clk);
        cfg_wr_en = en;
        cfg_wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_idle(input string req, input bit exp_done);
        chk(tag_wr_en == 1'b0, req, 64'(tag_wr_en), 0);
        chk(ls_stall == 1'b0, req, 64'(ls_stall), 0);
        chk(inv_done == exp_done, req, 64'(inv_done), 64'(exp_done));
        chk(cfg_rd_data == exp_other, req, 64'(cfg_rd_data), 64'(exp_other));
    endtask

    // Full walk with an optional second write of 1 at step retrig (-1 for none).
    task automatic run_walk(input int retrig, input logic [CTRL_W-1:0] d0, input logic [CTRL_W-1:0] d1);
        cyc(1'b1, d0 | INV_MASK);
        exp_other = d0 & ~INV_MASK;
        for (int k = 0; k < NUM_SETS; k++) begin
            chk(tag_wr_en == 1'b1, "R1/R3 tag write active", 64'(tag_wr_en), 1);
            chk(tag_wr_set == SET_W'(k), "R3 set order", 64'(tag_wr_set), 64'(k));
            chk(tag_wr_way_mask == '1 && tag_wr_valid == '0 && tag_wr_dirty == '0,
                "R4 clear all ways", 64'({tag_wr_way_mask, tag_wr_valid, tag_wr_dirty}),
                64'({{NUM_WAYS{1'b1}}, {2*NUM_WAYS{1'b0}}}));
            chk(ls_stall == 1'b1, "R5 stall during walk", 64'(ls_stall), 1);
            chk(cfg_rd_data == (exp_other | INV_MASK), "R6/R8 read during walk",
                64'(cfg_rd_data), 64'(exp_other | INV_MASK));
            chk(inv_done == 1'b0, "R7 no done mid walk", 64'(inv_done), 0);
            if (k == retrig) begin
                cyc(1'b1, d1 | INV_MASK);
                exp_other = d1 & ~INV_MASK;
            end else begin
                cyc(1'b0, '0);
            end
        end
        chk_idle("R6/R7/R8 completion", 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R9 reset state and no tag writes during or after reset
        repeat (3) cyc(1'b0, '0);
        chk_idle("R9 during reset", 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, '0);
            chk_idle("R9 after reset", 1'b0);
        end

        // R2 writes with command bit 0: stored, no walk
        for (int p = 0; p < 4; p++) begin
            logic [CTRL_W-1:0] d;
            d = (32'hA5A5_5A5A ^ (32'h0101_0101 * p)) & ~INV_MASK;
            cyc(1'b1, d);
            exp_other = d;
            chk_idle("R2 no start on zero bit", 1'b0);
            cyc(1'b0, '0);
            chk_idle("R2 still idle", 1'b0);
        end

        // R1/R3/R8 sweep of a second write of 1 over every step, back to back
        for (int r = -1; r < NUM_SETS; r++) begin
            run_walk(r, 32'h0000_1234 + 32'(r + 1), 32'h00F0_0F00 ^ 32'(r * 3));
        end
        cyc(1'b0, '0);
        chk_idle("R7 done lasts one cycle", 1'b0);
        cyc(1'b0, '0);
        chk_idle("R3 no extra walk after retrigger", 1'b0);

        // R9 reset in the middle of a walk
        cyc(1'b1, INV_MASK | 32'h0000_0055);
        cyc(1'b0, '0);
        cyc(1'b0, '0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        exp_other = '0;
        chk_idle("R9 reset stops walk", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, '0);
        chk_idle("R9 stays idle after reset", 1'b0);

        // R1 fresh walk after reset still works
        run_walk(-1, 32'h8000_0001, '0);
        cyc(1'b0, '0);
        chk_idle("R7 done single after fresh walk", 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule